// File: doc/BRIEF.md
# Busy-Cycle Load Monitor with Watermark Interrupt

The monitor watches a single busy signal from an engine and measures how heavily that engine is loaded. It splits time into back-to-back sampling windows whose length is set in clock cycles. In each window it counts the cycles in which the engine reports busy. When a window closes, a serial divider turns that count into a per-mille load figure, which is busy cycles times 1000 divided by the window length. The figure is presented on an output bus together with a one-cycle strobe.

Each finished load figure is compared against two programmable watermarks. A figure above the upper watermark sets one status bit and a figure below the lower watermark sets another. The interrupt line is the OR of the two bits. The bits remain set until the clear input is pulsed. A frequency governor can then use the strobe and the interrupt to decide when to change clock rate.

All settings are written through a small write-only register port. A new setting is applied at a window boundary, so a window that is already running always completes with one consistent set of values.

Top module: `load_monitor`

## Requirements
- R1: After reset the monitor is disabled, loadOut is 0, and loadValid, hiTrip, loTrip and irq are all low. The reset settings are a window of 1000 cycles, an upper watermark of 900 and a lower watermark of 100.
- R2: A write on the configuration port is a cycle with cfgWe high. The address selects the target: 0 writes the enable from data bit 0, 1 writes the window length from data bits 15:0, 2 writes the upper watermark from bits 9:0, and 3 writes the lower watermark from bits 9:0.
- R3: While enabled, windows of exactly W cycles follow one another with no gap, where W is the programmed window length. A programmed length below 27 is treated as 27.
- R4: For each window, loadOut takes the value floor(busyCycles*1000/W) and loadValid is high for exactly one cycle. That cycle is the 27th cycle after the last cycle of the window. loadOut keeps its value between strobes.
- R5: When a new load value is strictly above the upper watermark, hiTrip sets in the strobe cycle. When the value is strictly below the lower watermark, loTrip sets in the strobe cycle. A load equal to a watermark sets neither bit.
- R6: irq is hiTrip OR loTrip. Both bits stay set until a cycle with irqClr high clears them. If a new trip falls in the same cycle as a clear, the trip wins.
- R7: A change to the window length or to a watermark takes effect at the start of the next window. A window in progress, and the compare against its load, use the settings that were in force when that window began.
- R8: While disabled, the cycle and busy counters are held at zero. A load computation still in progress is discarded and produces no strobe. The status bits keep their values. Enabling again starts a fresh window in the first enabled cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busyIn | input | 1 | Engine busy indication, sampled every cycle |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | 2 | Configuration register select |
| cfgWdata | input | 16 | Configuration write data |
| irqClr | input | 1 | Clears both status bits |
| loadOut | output | 10 | Last computed per-mille load |
| loadValid | output | 1 | One-cycle strobe marking a new loadOut |
| hiTrip | output | 1 | Sticky flag: load exceeded the upper watermark |
| loTrip | output | 1 | Sticky flag: load fell below the lower watermark |
| irq | output | 1 | Interrupt request |

## Verification
The bench places busy counts exactly on the watermarks and one count to either side of them. A design that compares with the wrong inequality would trip on equality, or would fail to trip one step past the watermark. The bench writes window lengths below, at and just above the minimum. A design that does not clamp the length would restart the divider while it is still busy and report garbage loads. Settings are rewritten halfway through a window and the block is disabled while a quotient is pending. A design that applies settings at once, or that lets an aborted division finish, would strobe early or strobe at all. The clear input is timed to land on the very cycle a trip arrives. A design that gives the clear priority would lose that interrupt.

// File: rtl/lm_pkg.sv
package lm_pkg;

  // strobes from the control half to the datapath half
  typedef struct packed {
    logic countEn;   // a window is running this cycle
    logic winClose;  // this is the last cycle of the window
    logic flush;     // block disabled: zero counters, drop work
  } lmStrobeT;

  typedef enum logic [1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_WIN  = 2'd1,
    ADDR_HI   = 2'd2,
    ADDR_LO   = 2'd3
  } lmAddrE;

  localparam int unsigned LOAD_SCALE = 1000;
  localparam int unsigned LOAD_W     = 10;

endpackage

// File: rtl/lm_ctrl.sv
module lm_ctrl
  import lm_pkg::*;
#(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned MIN_WIN = 27,
  parameter int unsigned WIN_RST = 1000,
  parameter int unsigned HI_RST  = 900,
  parameter int unsigned LO_RST  = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfgWe,
  input  logic [1:0]        cfgAddr,
  input  logic [CNT_W-1:0]  cfgWdata,
  output lmStrobeT          ctl,
  output logic [CNT_W-1:0]  winAct,
  output logic [LOAD_W-1:0] hiAct,
  output logic [LOAD_W-1:0] loAct
);

  localparam logic [CNT_W-1:0]  minWinV = CNT_W'(MIN_WIN);
  localparam logic [CNT_W-1:0]  winRstV = (WIN_RST < MIN_WIN) ? CNT_W'(MIN_WIN) : CNT_W'(WIN_RST);
  localparam logic [CNT_W-1:0]  oneV    = CNT_W'(1);
  localparam logic [LOAD_W-1:0] hiRstV  = LOAD_W'(HI_RST);
  localparam logic [LOAD_W-1:0] loRstV  = LOAD_W'(LO_RST);

  logic              enReg;
  logic [CNT_W-1:0]  winCfg;
  logic [LOAD_W-1:0] hiCfg;
  logic [LOAD_W-1:0] loCfg;
  logic [CNT_W-1:0]  cycCnt;
  logic [CNT_W-1:0]  winClamp;
  logic              lastCyc;
  logic              reload;

  // programmed settings
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enReg  <= 1'b0;
      winCfg <= winRstV;
      hiCfg  <= hiRstV;
      loCfg  <= loRstV;
    end else if (cfgWe) begin
      case (lmAddrE'(cfgAddr))
        ADDR_CTRL: enReg  <= cfgWdata[0];
        ADDR_WIN:  winCfg <= cfgWdata;
        ADDR_HI:   hiCfg  <= cfgWdata[LOAD_W-1:0];
        ADDR_LO:   loCfg  <= cfgWdata[LOAD_W-1:0];
        default:   ;
      endcase
    end
  end

  assign winClamp = (winCfg < minWinV) ? minWinV : winCfg;
  assign lastCyc  = (cycCnt == winAct - oneV);
  assign reload   = !enReg || lastCyc;

  // window position and the settings frozen for the running window
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cycCnt <= '0;
      winAct <= winRstV;
      hiAct  <= hiRstV;
      loAct  <= loRstV;
    end else if (reload) begin
      cycCnt <= '0;
      winAct <= winClamp;
      hiAct  <= hiCfg;
      loAct  <= loCfg;
    end else begin
      cycCnt <= cycCnt + oneV;
    end
  end

  assign ctl.countEn  = enReg;
  assign ctl.winClose = enReg && lastCyc;
  assign ctl.flush    = !enReg;

  // R3: the window position never reaches the window length
  assert_cycle_in_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    enReg |-> (cycCnt < winAct));

  // R7: settings stay frozen for the whole of a running window
  assert_settings_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (enReg && $past(enReg) && cycCnt != '0) |->
      ($stable(hiAct) && $stable(loAct) && $stable(winAct)));

endmodule

// File: rtl/lm_div.sv
module lm_div #(
  parameter int unsigned NUM_W = 26,
  parameter int unsigned DEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             abort,
  input  logic [NUM_W-1:0] numIn,
  input  logic [DEN_W-1:0] denIn,
  output logic             finishing,
  output logic [NUM_W-1:0] quotNext
);

  localparam int unsigned SW = $clog2(NUM_W + 1);
  localparam logic [SW-1:0] stepsV = SW'(NUM_W);
  localparam logic [SW-1:0] oneV   = SW'(1);

  logic             running;
  logic [SW-1:0]    stepCnt;
  logic [NUM_W-1:0] numSh;
  logic [DEN_W-1:0] rem;
  logic [DEN_W-1:0] den;
  logic [DEN_W:0]   remTry;
  logic [DEN_W:0]   remSub;
  logic             fits;

  // one restoring step: quotient bits shift in where numerator bits leave
  assign remTry    = {rem, numSh[NUM_W-1]};
  assign fits      = remTry >= {1'b0, den};
  assign remSub    = remTry - {1'b0, den};
  assign quotNext  = {numSh[NUM_W-2:0], fits};
  assign finishing = running && !abort && (stepCnt == oneV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      stepCnt <= '0;
      numSh   <= '0;
      rem     <= '0;
      den     <= '0;
    end else if (abort) begin
      running <= 1'b0;
    end else if (start) begin
      running <= 1'b1;
      stepCnt <= stepsV;
      numSh   <= numIn;
      rem     <= '0;
      den     <= denIn;
    end else if (running) begin
      numSh   <= quotNext;
      rem     <= fits ? remSub[DEN_W-1:0] : remTry[DEN_W-1:0];
      stepCnt <= stepCnt - oneV;
      if (stepCnt == oneV) running <= 1'b0;
    end
  end

  // R3: the minimum window keeps a new start away from a running division
  assert_start_when_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !abort) |-> !running);

endmodule

// File: rtl/lm_datapath.sv
module lm_datapath
  import lm_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busyIn,
  input  lmStrobeT          ctl,
  input  logic [CNT_W-1:0]  winAct,
  input  logic [LOAD_W-1:0] hiAct,
  input  logic [LOAD_W-1:0] loAct,
  input  logic              irqClr,
  output logic [LOAD_W-1:0] loadOut,
  output logic              loadValid,
  output logic              hiTrip,
  output logic              loTrip
);

  localparam int unsigned NUM_W = CNT_W + LOAD_W;

  logic [CNT_W-1:0]  busyCnt;
  logic [CNT_W-1:0]  busyTot;
  logic [NUM_W-1:0]  scaledBusy;
  logic [LOAD_W-1:0] hiSnap;
  logic [LOAD_W-1:0] loSnap;
  logic              divFinishing;
  logic [NUM_W-1:0]  quotNext;
  logic              hiHit;
  logic              loHit;

  assign busyTot    = busyCnt + {{(CNT_W-1){1'b0}}, busyIn};
  assign scaledBusy = NUM_W'(busyTot) * NUM_W'(LOAD_SCALE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busyCnt <= '0;
      hiSnap  <= '0;
      loSnap  <= '0;
    end else if (ctl.flush) begin
      busyCnt <= '0;
    end else if (ctl.winClose) begin
      busyCnt <= '0;
      hiSnap  <= hiAct;
      loSnap  <= loAct;
    end else if (ctl.countEn) begin
      busyCnt <= busyTot;
    end
  end

  lm_div #(
    .NUM_W (NUM_W),
    .DEN_W (CNT_W)
  ) uDiv (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (ctl.winClose),
    .abort     (ctl.flush),
    .numIn     (scaledBusy),
    .denIn     (winAct),
    .finishing (divFinishing),
    .quotNext  (quotNext)
  );

  assign hiHit = divFinishing && (quotNext > NUM_W'(hiSnap));
  assign loHit = divFinishing && (quotNext < NUM_W'(loSnap));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loadOut   <= '0;
      loadValid <= 1'b0;
      hiTrip    <= 1'b0;
      loTrip    <= 1'b0;
    end else begin
      loadValid <= divFinishing;
      if (divFinishing) loadOut <= quotNext[LOAD_W-1:0];
      hiTrip <= (hiTrip && !irqClr) || hiHit;
      loTrip <= (loTrip && !irqClr) || loHit;
    end
  end

  assert_single_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    loadValid |=> !loadValid);

  assert_load_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    loadValid |-> (loadOut <= LOAD_W'(LOAD_SCALE)));

  assert_hi_with_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hiTrip) |-> loadValid);

  assert_lo_with_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(loTrip) |-> loadValid);

  assert_hi_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hiTrip && !irqClr) |=> hiTrip);

  assert_lo_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (loTrip && !irqClr) |=> loTrip);

  assert_no_strobe_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.flush |=> !loadValid);

endmodule

// File: rtl/load_monitor.sv
module load_monitor
  import lm_pkg::*;
#(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned WIN_RST = 1000,
  parameter int unsigned HI_RST  = 900,
  parameter int unsigned LO_RST  = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busyIn,
  input  logic              cfgWe,
  input  logic [1:0]        cfgAddr,
  input  logic [CNT_W-1:0]  cfgWdata,
  input  logic              irqClr,
  output logic [LOAD_W-1:0] loadOut,
  output logic              loadValid,
  output logic              hiTrip,
  output logic              loTrip,
  output logic              irq
);

  localparam int unsigned NUM_W   = CNT_W + LOAD_W;
  localparam int unsigned MIN_WIN = NUM_W + 1;

  lmStrobeT          ctl;
  logic [CNT_W-1:0]  winAct;
  logic [LOAD_W-1:0] hiAct;
  logic [LOAD_W-1:0] loAct;

  lm_ctrl #(
    .CNT_W   (CNT_W),
    .MIN_WIN (MIN_WIN),
    .WIN_RST (WIN_RST),
    .HI_RST  (HI_RST),
    .LO_RST  (LO_RST)
  ) uCtrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfgWe    (cfgWe),
    .cfgAddr  (cfgAddr),
    .cfgWdata (cfgWdata),
    .ctl      (ctl),
    .winAct   (winAct),
    .hiAct    (hiAct),
    .loAct    (loAct)
  );

  lm_datapath #(
    .CNT_W (CNT_W)
  ) uData (
    .clk       (clk),
    .rst_n     (rst_n),
    .busyIn    (busyIn),
    .ctl       (ctl),
    .winAct    (winAct),
    .hiAct     (hiAct),
    .loAct     (loAct),
    .irqClr    (irqClr),
    .loadOut   (loadOut),
    .loadValid (loadValid),
    .hiTrip    (hiTrip),
    .loTrip    (loTrip)
  );

  assign irq = hiTrip || loTrip;

endmodule

// File: tb/load_monitor_test.sv
module load_monitor_test;

  localparam int LAT = 27;  // divider length plus the output register

  logic        clk = 1'b0;
  logic        rst_n;
  logic        busyIn;
  logic        cfgWe;
  logic [1:0]  cfgAddr;
  logic [15:0] cfgWdata;
  logic        irqClr;
  logic [9:0]  loadOut;
  logic        loadValid, hiTrip, loTrip, irq;

  always #4 clk = ~clk;

  load_monitor uut (
    .clk(clk), .rst_n(rst_n), .busyIn(busyIn), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgWdata(cfgWdata), .irqClr(irqClr), .loadOut(loadOut), .loadValid(loadValid),
    .hiTrip(hiTrip), .loTrip(loTrip), .irq(irq)
  );

  typedef struct { int due; int load; int hi; int lo; } resT;
  resT pend[$];
  resT r;

  int mEn, mWinCfg, mHiCfg, mLoCfg, mWinAct, mHiAct, mLoAct, mCyc, mBusy, nowCyc;
  int eValid, eLoad, eHi, eLo;
  int closeNow, hHit, lHit;
  int nChk = 0, nFail = 0;
  int busyMode = 0, pct = 0, kBusy = 0, busyLvl = 0;
  int clrReq = 0, clrAuto = 0;
  int wdog = 0;
  string phase = "R1 reset";

  function automatic int clampWin(int v);
    return (v < LAT) ? LAT : v;
  endfunction

  // behavioural reference, one step per clock edge
  always @(posedge clk) begin
    if (!rst_n) begin
      mEn = 0; mWinCfg = 1000; mHiCfg = 900; mLoCfg = 100;
      mWinAct = 1000; mHiAct = 900; mLoAct = 100; mCyc = 0; mBusy = 0;
      eValid = 0; eLoad = 0; eHi = 0; eLo = 0; nowCyc = 0;
      pend.delete();
    end else begin
      closeNow = (mEn != 0 && mCyc == mWinAct - 1) ? 1 : 0;
      hHit = 0; lHit = 0;
      if (mEn == 0) pend.delete();
      else if (closeNow != 0)
        pend.push_back('{nowCyc + 1 + LAT - 1, ((mBusy + int'(busyIn)) * 1000) / mWinAct, mHiAct, mLoAct});
      eValid = 0;
      if (pend.size() > 0 && pend[0].due == nowCyc + 1) begin
        r = pend.pop_front();
        eValid = 1; eLoad = r.load;
        hHit = (r.load > r.hi) ? 1 : 0;
        lHit = (r.load < r.lo) ? 1 : 0;
      end
      eHi = ((eHi != 0 && !irqClr) || hHit != 0) ? 1 : 0;
      eLo = ((eLo != 0 && !irqClr) || lHit != 0) ? 1 : 0;
      if (mEn == 0 || closeNow != 0) begin
        mBusy = 0; mCyc = 0;
        mWinAct = clampWin(mWinCfg); mHiAct = mHiCfg; mLoAct = mLoCfg;
      end else begin
        mBusy = mBusy + int'(busyIn); mCyc = mCyc + 1;
      end
      if (cfgWe) begin
        case (cfgAddr)
          2'd0: mEn = int'(cfgWdata[0]);
          2'd1: mWinCfg = int'(cfgWdata);
          2'd2: mHiCfg = int'(cfgWdata[9:0]);
          default: mLoCfg = int'(cfgWdata[9:0]);
        endcase
      end
      nowCyc = nowCyc + 1;
    end
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL [%s] %s: actual %0d expected %0d", phase, what, act, exp);
    end
  endtask

  function automatic void summary();
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
  endfunction

  // compare on every cycle, then drive the stimulus for the next edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk(int'(loadValid) == eValid, "R4 loadValid", int'(loadValid), eValid);
      chk(int'(loadOut) == eLoad, "R4 loadOut", int'(loadOut), eLoad);
      chk(int'(hiTrip) == eHi, "R5 hiTrip", int'(hiTrip), eHi);
      chk(int'(loTrip) == eLo, "R5 loTrip", int'(loTrip), eLo);
      chk(int'(irq) == ((eHi != 0 || eLo != 0) ? 1 : 0), "R6 irq", int'(irq), (eHi != 0 || eLo != 0) ? 1 : 0);
    end
    case (busyMode)
      0: busyIn = (busyLvl != 0);
      1: busyIn = (($urandom % 100) < pct);
      default: busyIn = (mCyc < kBusy);
    endcase
    irqClr = (clrReq != 0) || (clrAuto != 0 && pend.size() > 0 && pend[0].due == nowCyc + 1);
  end

  always @(posedge clk) begin
    wdog++;
    if (wdog > 150000) begin
      nChk++; nFail++;
      $display("FAIL [%s] watchdog expired: actual %0d expected %0d", phase, wdog, 150000);
      summary();
      $finish;
    end
  end

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wrCfg(input logic [1:0] a, input int d);
    cfgAddr = a; cfgWdata = 16'(d); cfgWe = 1'b1;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic pulseClr();
    clrReq = 1; waitCyc(1); clrReq = 0; waitCyc(1);
  endtask

  initial begin
    rst_n = 1'b0; busyIn = 1'b0; cfgWe = 1'b0; cfgAddr = 2'd0; cfgWdata = '0; irqClr = 1'b0;
    waitCyc(4);
    rst_n = 1'b1;
    waitCyc(3);
    chk(loadOut == 10'd0 && !irq && !loadValid, "R1 reset outputs", int'(loadOut), 0);

    // R2 R3: exact 70% load on a 100-cycle window equals the upper mark
    phase = "R2 R3 band";
    wrCfg(2'd1, 100); wrCfg(2'd2, 700); wrCfg(2'd3, 300);
    busyMode = 2; kBusy = 70;
    wrCfg(2'd0, 1);
    waitCyc(450);
    chk(!irq, "R5 equal to upper mark", int'(irq), 0);

    // R5: on and one step past each watermark
    phase = "R5 lower edge";
    kBusy = 30; waitCyc(300);
    chk(!loTrip, "R5 equal to lower mark", int'(loTrip), 0);
    kBusy = 29; waitCyc(250);
    chk(loTrip, "R5 below lower mark", int'(loTrip), 1);
    phase = "R5 upper edge";
    kBusy = 71; waitCyc(250);
    chk(hiTrip, "R5 above upper mark", int'(hiTrip), 1);

    // R6: clear, then stay quiet inside the band
    phase = "R6 clear";
    kBusy = 50; waitCyc(150);
    pulseClr();
    waitCyc(250);
    chk(!irq, "R6 cleared stays low", int'(irq), 0);

    // R4: random densities on an odd window
    phase = "R4 random";
    wrCfg(2'd1, 137); wrCfg(2'd2, 1000); wrCfg(2'd3, 0);
    busyMode = 1; pct = 50; waitCyc(137 * 20);
    wrCfg(2'd2, 500); wrCfg(2'd3, 400); pct = 45; waitCyc(137 * 20);
    pulseClr();
    busyMode = 0; busyLvl = 1; waitCyc(137 * 3);
    busyLvl = 0; waitCyc(137 * 3);

    // R3: short windows are clamped to the minimum
    phase = "R3 clamp";
    pulseClr();
    busyMode = 1; pct = 60;
    wrCfg(2'd1, 5); waitCyc(27 * 12);
    wrCfg(2'd1, 0); waitCyc(27 * 6);
    wrCfg(2'd1, 27); waitCyc(27 * 6);
    wrCfg(2'd1, 28); waitCyc(28 * 6);

    // R7: settings written halfway through a window
    phase = "R7 staging";
    wrCfg(2'd1, 200); wrCfg(2'd2, 900); wrCfg(2'd3, 100);
    busyMode = 2; kBusy = 150;
    waitCyc(500);
    pulseClr();
    while (mCyc != 100) @(negedge clk);
    wrCfg(2'd2, 600);
    wrCfg(2'd1, 80);
    waitCyc(600);

    // R6: clear lands on the trip cycle
    phase = "R6 clear vs trip";
    clrAuto = 1; waitCyc(600); clrAuto = 0; waitCyc(200);

    // R8: disable with a quotient pending, then re-enable
    phase = "R8 disable";
    while (pend.size() == 0) @(negedge clk);
    waitCyc(5);
    wrCfg(2'd0, 0);
    waitCyc(80);
    chk(!loadValid, "R8 no strobe while off", int'(loadValid), 0);
    wrCfg(2'd3, 1000);
    wrCfg(2'd0, 1);
    waitCyc(300);

    // R4: long window with scattered busy cycles
    phase = "R4 long window";
    pulseClr();
    wrCfg(2'd1, 3001); wrCfg(2'd3, 0);
    busyMode = 1; pct = 30;
    waitCyc(3001 * 3 + 100);

    summary();
    $finish;
  end

endmodule